// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block keeps a position count from two external encoder pins, called channel A and channel B here. Both pins are brought into the clock domain through a synchronizer chain, then edges are found by comparing each synchronized sample with the one before it. The counter either counts every qualified edge of channel A upwards (plain mode), or decodes A and B as a quadrature pair (quadrature mode). In quadrature mode the counting direction of each edge comes from the level of the other channel at that moment.

An edge-select input picks which edges count: rising only, falling only, or both. With both edges selected a full encoder cycle gives four counts. The count runs between 0 and a preset limit taken from an input port. Stepping up past the limit goes to 0, and stepping down past 0 goes to the limit. Each wrap is marked with a one-cycle pulse. A quadrature sample in which both channels changed together cannot be decoded. It is dropped and a sticky error flag is raised.

Top module: `qenc_counter`

## Requirements
- R1: After reset, count_o is 0, dir_up_o is 1, wrap_o is 0 and err_o is 0.
- R2: A pin change reaches count_o on the (SYNC_STAGES+1)-th rising clock edge after it is applied, and not earlier.
- R3: With quad_mode_i = 0, each qualified edge of enc_a_i adds one to the count. enc_b_i has no effect on the count or on the direction.
- R4: edge_sel_i encoding: 0 selects rising edges only, 1 selects falling edges only, and 2 or 3 selects both edges. Edges that are not selected are ignored.
- R5: Quadrature rising-edge rule: a rise of A counts up when B is low and down when B is high. A rise of B counts up when A is high and down when A is low.
- R6: Quadrature falling-edge rule: a fall of A counts up when B is high and down when B is low. A fall of B counts up when A is low and down when A is high.
- R7: With both edges selected in quadrature mode, the sequence A,B = 00,10,11,01,00 gives four up counts, and the reverse sequence gives four down counts.
- R8: An up count from a value at or above preset_i loads 0 and pulses wrap_o high for one cycle.
- R9: A down count from 0 loads preset_i and pulses wrap_o high for one cycle.
- R10: preset_i is used as it stands at each counted edge, so a new value takes effect at the next count. A preset of 0 holds the count at 0, and every up count then wraps.
- R11: In quadrature mode, a sample in which both channels changed does not count, and it sets err_o. err_o stays set until reset.
- R12: While en_i is low, the count is cleared to 0 on the next clock and held there. Edges during that time change neither the count nor the direction.
- R13: dir_up_o holds the direction of the last counted edge (1 = up).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Count enable; low clears and holds the count |
| quad_mode_i | input | 1 | 1 = quadrature decode of A and B, 0 = plain count of A |
| edge_sel_i | input | 2 | Active-edge select (0 rising, 1 falling, 2/3 both) |
| preset_i | input | CNT_W | Wrap limit of the count |
| enc_a_i | input | 1 | Encoder channel A, asynchronous |
| enc_b_i | input | 1 | Encoder channel B, asynchronous |
| count_o | output | CNT_W | Position count |
| dir_up_o | output | 1 | Direction of the last counted edge |
| wrap_o | output | 1 | One-cycle pulse on a wrap |
| err_o | output | 1 | Sticky flag for an undecodable sample |

## Verification
The bench builds the block with CNT_W = 4 and SYNC_STAGES = 2. The narrow counter lets the bench reach the full-scale preset of 15 and wrap past it within sixteen quadrature steps. The two-stage chain gives a fixed three-edge latency, and the bench checks that no count appears one edge earlier. Preset values of 5, 15, 2 and 0 cover wrapping in both directions, a change of limit while running, and the degenerate zero limit.

// File: rtl/qenc_pkg.sv
package qenc_pkg;
  typedef enum logic [1:0] {
    EDGE_RISE     = 2'b00,
    EDGE_FALL     = 2'b01,
    EDGE_BOTH     = 2'b10,
    EDGE_BOTH_ALT = 2'b11
  } edge_sel_e;

  typedef struct packed {
    logic step;
    logic up;
    logic bad;
  } step_t;
endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] sr;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sr <= '0;
      else         sr <= {sr[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = sr[STAGES-1];
  end
endmodule

// File: rtl/qenc_decode.sv
module qenc_decode
  import qenc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      a_i,
  input  logic      b_i,
  input  logic      quad_i,
  input  edge_sel_e edge_sel_i,
  output step_t     step_o
);
  logic prev_a, prev_b;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_a <= 1'b0;
      prev_b <= 1'b0;
    end else begin
      prev_a <= a_i;
      prev_b <= b_i;
    end
  end

  logic a_rise, a_fall, b_rise, b_fall;
  logic use_rise, use_fall, a_act, b_act;

  always_comb begin
    a_rise   = a_i & ~prev_a;
    a_fall   = ~a_i & prev_a;
    b_rise   = b_i & ~prev_b;
    b_fall   = ~b_i & prev_b;
    use_rise = (edge_sel_i != EDGE_FALL);
    use_fall = (edge_sel_i != EDGE_RISE);
    a_act    = (a_rise & use_rise) | (a_fall & use_fall);
    b_act    = (b_rise & use_rise) | (b_fall & use_fall);

    step_o = '0;
    if (!quad_i) begin
      step_o.step = a_act;
      step_o.up   = 1'b1;
    end else if ((a_rise | a_fall) && (b_rise | b_fall)) begin
      step_o.bad = 1'b1;
    end else if (a_act) begin
      step_o.step = 1'b1;
      step_o.up   = a_rise ? ~b_i : b_i;   // other input level sets direction
    end else if (b_act) begin
      step_o.step = 1'b1;
      step_o.up   = b_rise ? a_i : ~a_i;
    end
  end
endmodule

// File: rtl/qenc_count.sv
module qenc_count
  import qenc_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  step_t            step_i,
  input  logic [CNT_W-1:0] preset_i,
  output logic [CNT_W-1:0] count_o,
  output logic             dir_up_o,
  output logic             wrap_o,
  output logic             err_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_o  <= '0;
      dir_up_o <= 1'b1;
      wrap_o   <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      wrap_o <= 1'b0;
      if (!en_i) begin
        count_o <= '0;
      end else begin
        if (step_i.bad) err_o <= 1'b1;
        if (step_i.step) begin
          dir_up_o <= step_i.up;
          if (step_i.up) begin
            if (count_o >= preset_i) begin
              count_o <= '0;
              wrap_o  <= 1'b1;
            end else begin
              count_o <= count_o + ONE;
            end
          end else if (count_o == '0) begin
            count_o <= preset_i;
            wrap_o  <= 1'b1;
          end else begin
            count_o <= count_o - ONE;
          end
        end
      end
    end
  end
endmodule

// File: rtl/qenc_counter.sv
module qenc_counter
  import qenc_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             quad_mode_i,
  input  logic [1:0]       edge_sel_i,
  input  logic [CNT_W-1:0] preset_i,
  input  logic             enc_a_i,
  input  logic             enc_b_i,
  output logic [CNT_W-1:0] count_o,
  output logic             dir_up_o,
  output logic             wrap_o,
  output logic             err_o
);
  logic [1:0] pins_sync;
  step_t      step;

  qenc_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({enc_b_i, enc_a_i}),
    .q_o    (pins_sync)
  );

  qenc_decode i_decode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .a_i        (pins_sync[0]),
    .b_i        (pins_sync[1]),
    .quad_i     (quad_mode_i),
    .edge_sel_i (edge_sel_e'(edge_sel_i)),
    .step_o     (step)
  );

  qenc_count #(.CNT_W(CNT_W)) i_count (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .step_i   (step),
    .preset_i (preset_i),
    .count_o  (count_o),
    .dir_up_o (dir_up_o),
    .wrap_o   (wrap_o),
    .err_o    (err_o)
  );
endmodule

// File: rtl/qenc_checker.sv
module qenc_checker #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic [CNT_W-1:0] count_o,
  input logic             dir_up_o,
  input logic             wrap_o,
  input logic             err_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assert_enable_clear_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> count_o == '0);

  assert_err_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  assert_up_wrap_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o && dir_up_o |-> count_o == '0);

  assert_unit_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(en_i) && !wrap_o && count_o != $past(count_o)
      |-> (count_o == $past(count_o) + ONE) || (count_o == $past(count_o) - ONE));

  assert_dir_on_count_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_up_o != $past(dir_up_o) |-> (count_o != $past(count_o)) || wrap_o);
endmodule

bind qenc_counter qenc_checker #(.CNT_W(CNT_W)) i_qenc_checker (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_i     (en_i),
  .count_o  (count_o),
  .dir_up_o (dir_up_o),
  .wrap_o   (wrap_o),
  .err_o    (err_o)
);

// File: tb/test_qenc_counter.sv
module test_qenc_counter;
  localparam int unsigned CNT_W = 4;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             en = 1'b1;
  logic             quad = 1'b0;
  logic [1:0]       esel = 2'd0;
  logic [CNT_W-1:0] preset = 4'd5;
  logic             pa = 1'b0, pb = 1'b0;
  logic [CNT_W-1:0] count;
  logic             dir_up, wrap, err;

  int checks = 0;
  int errors = 0;
  logic [CNT_W-1:0] exp_cnt = '0;
  logic             exp_dir = 1'b1;

  always #10 clk = ~clk;

  qenc_counter #(.CNT_W(CNT_W), .SYNC_STAGES(2)) i_qenc_counter (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .quad_mode_i(quad),
    .edge_sel_i(esel), .preset_i(preset), .enc_a_i(pa), .enc_b_i(pb),
    .count_o(count), .dir_up_o(dir_up), .wrap_o(wrap), .err_o(err)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive pins, confirm latency, then compare with the expected step (+1/-1/0)
  task automatic move(input logic a, input logic b, input int delta, input string req);
    logic exp_w;
    @(negedge clk); pa = a; pb = b;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R2 no early count", int'(count), int'(exp_cnt));
    exp_w = 1'b0;
    if (delta > 0) begin
      exp_dir = 1'b1;
      if (exp_cnt >= preset) begin exp_cnt = '0; exp_w = 1'b1; end
      else exp_cnt = exp_cnt + 1'b1;
    end else if (delta < 0) begin
      exp_dir = 1'b0;
      if (exp_cnt == '0) begin exp_cnt = preset; exp_w = 1'b1; end
      else exp_cnt = exp_cnt - 1'b1;
    end
    @(posedge clk); @(negedge clk);
    check({req, " count"}, int'(count), int'(exp_cnt));
    check({req, " wrap"},  int'(wrap),  int'(exp_w));
    check({req, " dir"},   int'(dir_up), int'(exp_dir));
  endtask

  task automatic fwd(input int delta, input string req);
    move(~pb, pa, delta, req);
  endtask

  task automatic rev(input int delta, input string req);
    move(pb, ~pa, delta, req);
  endtask

  task automatic t_reset;
    check("R1 count", int'(count), 0);
    check("R1 dir", int'(dir_up), 1);
    check("R1 wrap", int'(wrap), 0);
    check("R1 err", int'(err), 0);
  endtask

  task automatic t_plain;
    quad = 1'b0; esel = 2'd0;
    move(1, 0, 1, "R3 rise A");
    move(0, 0, 0, "R4 fall A ignored");
    move(0, 1, 0, "R3 B ignored");
    move(0, 0, 0, "R3 B ignored");
    move(1, 0, 1, "R3 rise A");
    move(0, 0, 0, "R4 fall A ignored");
    esel = 2'd2;
    move(1, 0, 1, "R4 both rise");
    move(0, 0, 1, "R4 both fall");
    esel = 2'd3;
    move(1, 0, 1, "R4 alt both");
    move(0, 0, 1, "R8 plain wrap");
  endtask

  task automatic t_quad_both;
    quad = 1'b1; esel = 2'd2;
    for (int i = 0; i < 4; i++) fwd(1, "R7 forward");
    for (int i = 0; i < 4; i++) rev(-1, "R7 reverse");
    rev(-1, "R9 down wrap");
    fwd(1, "R8 up wrap");
  endtask

  task automatic t_quad_rise;
    esel = 2'd0;
    fwd(1, "R5 A rise B low");
    fwd(1, "R5 B rise A high");
    fwd(0, "R5 A fall ignored");
    fwd(0, "R5 B fall ignored");
    rev(-1, "R5 B rise A low");
    rev(-1, "R5 A rise B high");
    rev(0, "R13 dir held");
    rev(0, "R13 dir held");
  endtask

  task automatic t_quad_fall;
    esel = 2'd1;
    fwd(0, "R6 A rise ignored");
    fwd(0, "R6 B rise ignored");
    fwd(1, "R6 A fall B high");
    fwd(1, "R6 B fall A low");
    rev(0, "R6 B rise ignored");
    rev(0, "R6 A rise ignored");
    rev(-1, "R6 B fall A high");
    rev(-1, "R6 A fall B low");
  endtask

  task automatic t_preset;
    esel = 2'd2;
    @(negedge clk); preset = 4'd15;
    for (int i = 0; i < 16; i++) fwd(1, "R10 full scale");
    @(negedge clk); preset = 4'd2;
    rev(-1, "R10 new preset down wrap");
    @(negedge clk); preset = 4'd0;
    fwd(1, "R10 zero preset wrap");
    fwd(1, "R10 zero preset wrap");
    @(negedge clk); preset = 4'd5;
    fwd(1, "R10 restore");
  endtask

  task automatic t_enable;
    @(negedge clk); en = 1'b0;
    @(posedge clk); @(negedge clk);
    exp_cnt = '0;
    check("R12 cleared", int'(count), 0);
    rev(0, "R12 edge ignored");
    rev(0, "R12 edge ignored");
    @(negedge clk); en = 1'b1;
    fwd(1, "R12 resume");
  endtask

  task automatic t_error;
    check("R11 err clear", int'(err), 0);
    move(~pa, ~pb, 0, "R11 dual change");
    check("R11 err set", int'(err), 1);
    fwd(1, "R11 count after error");
    check("R11 err sticky", int'(err), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset;
    t_plain;
    t_quad_both;
    t_quad_rise;
    t_quad_fall;
    t_preset;
    t_enable;
    t_error;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule